// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block checks each memory access from a processor against eight programmable protection regions. Each region has a base address, a power-of-two size between 4 KB and 4 MB, an enable bit, a cacheable flag, a bufferable flag and a 4-bit permission code. The permission code gives separate rights to privileged and user code. Software loads the regions one at a time through a register-write port. Each access request carries an address, a read/write direction and a privileged/user flag. One clock later the block answers with a fault flag and the memory attributes of the region that decided the access.

Regions may overlap. When more than one enabled region covers an address, the region with the highest index decides both the rights and the attributes. An address that no enabled region covers is refused. Permission codes outside the defined set refuse every access. The block holds only the region table and the registered response. It has no page tables and no address translation.

Top module: `mpu_guard`

## Requirements
- R1: After a synchronous reset, every region is disabled and `rsp_valid` is low. A request sent after reset therefore faults and reports cacheable=0 and bufferable=0.
- R2: A write with `cfg_we`=1 loads region `cfg_idx` (0 to 7) and leaves the other regions unchanged. The new setting first affects a request presented in the cycle after the write. A request in the same cycle as the write is judged against the old table.
- R3: A size code k from 0 to 10 gives a region of 4096·2^k bytes, so code 0 is 4 KB and code 10 is 4 MB. Codes 11 to 15 behave as code 10.
- R4: A region covers an address when the address bits at position 12+k and above equal the same bits of the programmed base. Base bits below 12+k have no effect.
- R5: If several enabled regions cover an address, the highest-numbered one supplies the permission result and both attributes.
- R6: An access that no enabled region covers faults and reports cacheable=0 and bufferable=0.
- R7: The permission code gives rights as privileged/user. 0000 gives none/none. 0001 gives read-write/none. 0010 gives read-write/read. 0011 gives read-write/read-write. 0101 gives read/none. 0110 gives read/read. A write without write right faults, and a read without read right faults.
- R8: Codes 0100 and 0111, and every code with bit 3 set, fault every access in both modes.
- R9: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid`=1. When no request arrives, the response fields keep their last values.
- R10: The reported cacheable and bufferable flags come from the deciding region even when that region refuses the access.
- R11: A disabled region covers nothing, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 3 | Index of the region to write |
| cfg_base | input | 32 | Region base address (bits 11:0 ignored) |
| cfg_size | input | 4 | Size code k, region is 4 KB·2^k |
| cfg_en | input | 1 | Region enable |
| cfg_cache | input | 1 | Region cacheable flag |
| cfg_buf | input | 1 | Region bufferable flag |
| cfg_perm | input | 4 | Region permission code |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_fault | output | 1 | Access refused |
| rsp_cacheable | output | 1 | Cacheable flag of the deciding region |
| rsp_bufferable | output | 1 | Bufferable flag of the deciding region |

## Verification
Two situations are the hardest to reach from the ports. The first is a region that is covered by a higher-numbered region, where the lower region's rights and attributes must lose. The bench sets this up with a 4 MB region and a small region inside it that differ in permission and attributes, and it probes addresses inside and outside the small region. It then disables the higher region or swaps the indices so that the lower region takes over. The second is a write and a request in the same cycle. The bench drives both in one cycle and checks that the response still follows the old table. Base bits that fall below the region size, and size codes above the largest legal value, are also set on purpose at the edges of each region.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int REGION_COUNT  = 8;
    localparam int ADDR_W        = 32;
    localparam int PAGE_SHIFT    = 12;
    localparam int SIZE_CODE_W   = 4;
    localparam int MAX_SIZE_CODE = 10;
    localparam int PERM_W        = 4;
    localparam int IDX_W         = $clog2(REGION_COUNT);
    localparam int BASE_W        = ADDR_W - PAGE_SHIFT;

    typedef struct packed {
        logic                   enable;
        logic [BASE_W-1:0]      base;
        logic [SIZE_CODE_W-1:0] size_code;
        logic                   cacheable;
        logic                   bufferable;
        logic [PERM_W-1:0]      perm;
    } region_cfg_t;

    typedef struct packed {
        logic priv_rd;
        logic priv_wr;
        logic user_rd;
        logic user_wr;
    } rights_t;

    // Effective size code after clamping to the largest legal region.
    function automatic logic [SIZE_CODE_W-1:0] clamp_size(input logic [SIZE_CODE_W-1:0] code);
        return (code > SIZE_CODE_W'(MAX_SIZE_CODE)) ? SIZE_CODE_W'(MAX_SIZE_CODE) : code;
    endfunction

    // Ones on the address bits that take part in the region compare.
    function automatic logic [ADDR_W-1:0] compare_mask(input logic [SIZE_CODE_W-1:0] code);
        logic [ADDR_W-1:0] m;
        int unsigned       low;
        low = PAGE_SHIFT + int'(clamp_size(code));
        for (int b = 0; b < ADDR_W; b++) begin
            m[b] = (b >= int'(low));
        end
        return m;
    endfunction

    function automatic rights_t decode_perm(input logic [PERM_W-1:0] code);
        rights_t r;
        r = '0;
        case (code)
            4'b0001: r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b0, user_wr: 1'b0};
            4'b0010: r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b0};
            4'b0011: r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b1};
            4'b0101: r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b0, user_wr: 1'b0};
            4'b0110: r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b1, user_wr: 1'b0};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mpu_region_regs.sv
module mpu_region_regs
    import mpu_pkg::*;
#(
    parameter int N = REGION_COUNT,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IW-1:0]        idx,
    input  region_cfg_t          wdata,
    output region_cfg_t [N-1:0]  regions
);

    logic [N-1:0] en_vec;

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[i] <= '0;
            end else if (we && idx == IW'(i)) begin
                regions[i] <= wdata;
            end
        end
        assign en_vec[i] = regions[i].enable;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (en_vec == '0));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (regions[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int N = REGION_COUNT
) (
    input  region_cfg_t [N-1:0] regions,
    input  logic [ADDR_W-1:0]   addr,
    output logic [N-1:0]        hit
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [ADDR_W-1:0] base_full;
        logic [ADDR_W-1:0] mask;
        assign base_full = {regions[i].base, {PAGE_SHIFT{1'b0}}};
        assign mask      = compare_mask(regions[i].size_code);
        assign hit[i]    = regions[i].enable && (((addr ^ base_full) & mask) == '0);
    end

endmodule

// File: rtl/mpu_priority_sel.sv
module mpu_priority_sel
    import mpu_pkg::*;
#(
    parameter int N = REGION_COUNT,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hit,
    output logic          found,
    output logic [IW-1:0] winner
);

    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                found  = 1'b1;
                winner = IW'(i);
            end
        end
    end

    assert_winner_hits_R5: assert property (@(posedge clk) disable iff (rst)
        found |-> hit[winner]);

    assert_winner_highest_R5: assert property (@(posedge clk) disable iff (rst)
        found |-> ((hit >> winner) == 1));

    assert_miss_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !found |-> (hit == '0));

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
    import mpu_pkg::*;
#(
    parameter int N = REGION_COUNT,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IW-1:0]          cfg_idx,
    input  logic [ADDR_W-1:0]      cfg_base,
    input  logic [SIZE_CODE_W-1:0] cfg_size,
    input  logic                   cfg_en,
    input  logic                   cfg_cache,
    input  logic                   cfg_buf,
    input  logic [PERM_W-1:0]      cfg_perm,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    input  logic                   req_priv,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic                   rsp_cacheable,
    output logic                   rsp_bufferable
);

    region_cfg_t          wdata;
    region_cfg_t [N-1:0]  regions;
    logic [N-1:0]         hit;
    logic                 found;
    logic [IW-1:0]        winner;
    region_cfg_t          sel;
    rights_t              rights;
    logic                 allowed;

    assign wdata = '{enable:     cfg_en,
                     base:       cfg_base[ADDR_W-1:PAGE_SHIFT],
                     size_code:  cfg_size,
                     cacheable:  cfg_cache,
                     bufferable: cfg_buf,
                     perm:       cfg_perm};

    mpu_region_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (wdata),
        .regions (regions)
    );

    mpu_region_match #(.N(N)) u_match (
        .regions (regions),
        .addr    (req_addr),
        .hit     (hit)
    );

    mpu_priority_sel #(.N(N)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .found  (found),
        .winner (winner)
    );

    assign sel    = regions[winner];
    assign rights = decode_perm(sel.perm);

    always_comb begin
        if (req_priv) allowed = req_write ? rights.priv_wr : rights.priv_rd;
        else          allowed = req_write ? rights.user_wr : rights.user_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_cacheable  <= 1'b0;
            rsp_bufferable <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault      <= !(found && allowed);
                rsp_cacheable  <= found && sel.cacheable;
                rsp_bufferable <= found && sel.bufferable;
            end
        end
    end

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !$past(rst)) |=> ($stable(rsp_fault) && $stable(rsp_cacheable) && $stable(rsp_bufferable)));

    assert_miss_faults_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit == '0) |=> (rsp_fault && !rsp_cacheable && !rsp_bufferable));

endmodule

// File: tb/mpu_guard_bench.sv
module mpu_guard_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_base;
    logic [3:0]  cfg_size;
    logic        cfg_en, cfg_cache, cfg_buf;
    logic [3:0]  cfg_perm;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_write, req_priv;
    logic        rsp_valid, rsp_fault, rsp_cacheable, rsp_bufferable;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mpu_guard u_mpu_guard (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_en(cfg_en), .cfg_cache(cfg_cache), .cfg_buf(cfg_buf), .cfg_perm(cfg_perm),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Rights {priv_rd, priv_wr, user_rd, user_wr} derived from R7/R8.
    function automatic logic [3:0] ref_rights(input logic [3:0] p);
        case (p)
            4'd1:    return 4'b1100;
            4'd2:    return 4'b1110;
            4'd3:    return 4'b1111;
            4'd5:    return 4'b1000;
            4'd6:    return 4'b1010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic write_region(input int idx, input logic [31:0] base, input logic [3:0] sz,
                                input logic en, input logic c, input logic b, input logic [3:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = sz;
        cfg_en = en; cfg_cache = c; cfg_buf = b; cfg_perm = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) write_region(i, 32'h0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic access(input string req, input logic [31:0] addr, input logic wr, input logic pv,
                          input logic ef, input logic ec, input logic eb);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_priv = pv;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid R9"}, 32'(rsp_valid), 32'd1);
        check({req, " fault"},    32'(rsp_fault), 32'(ef));
        check({req, " cache"},    32'(rsp_cacheable), 32'(ec));
        check({req, " buffer"},   32'(rsp_bufferable), 32'(eb));
    endtask

    task automatic test_reset();
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        access("R1 R6 empty table", 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_perm_table();
        for (int p = 0; p < 16; p++) begin
            logic [3:0] r;
            r = ref_rights(4'(p));
            write_region(0, 32'h0000_0000, 4'd0, 1'b1, 1'b0, 1'b0, 4'(p));
            access($sformatf("R7 R8 code %0d priv rd", p), 32'h10, 1'b0, 1'b1, !r[3], 1'b0, 1'b0);
            access($sformatf("R7 R8 code %0d priv wr", p), 32'h10, 1'b1, 1'b1, !r[2], 1'b0, 1'b0);
            access($sformatf("R7 R8 code %0d user rd", p), 32'h10, 1'b0, 1'b0, !r[1], 1'b0, 1'b0);
            access($sformatf("R7 R8 code %0d user wr", p), 32'h10, 1'b1, 1'b0, !r[0], 1'b0, 1'b0);
        end
        clear_all();
    endtask

    task automatic test_size_and_base();
        write_region(1, 32'h0010_3456, 4'd4, 1'b1, 1'b1, 1'b0, 4'd3);
        access("R4 low base bits ignored", 32'h0010_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        access("R3 64KB top edge",         32'h0010_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        access("R3 R6 past 64KB",          32'h0011_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R4 below base",            32'h000F_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        write_region(1, 32'h0040_0000, 4'd15, 1'b1, 1'b0, 1'b1, 4'd3);
        access("R3 code 15 as 4MB inside", 32'h007F_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        access("R3 code 15 as 4MB beyond", 32'h0080_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        write_region(1, 32'h0000_0000, 4'd0, 1'b1, 1'b1, 1'b1, 4'd3);
        access("R3 4KB last byte",  32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        access("R3 4KB next page",  32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        clear_all();
    endtask

    task automatic test_overlap();
        write_region(2, 32'h0000_0000, 4'd10, 1'b1, 1'b1, 1'b0, 4'd3);
        write_region(5, 32'h0000_2000, 4'd0,  1'b1, 1'b0, 1'b1, 4'd1);
        access("R5 R10 high region user faults", 32'h0000_2004, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        access("R5 high region priv write",      32'h0000_2004, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        access("R5 outside small region",        32'h0000_3000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        write_region(5, 32'h0000_2000, 4'd0,  1'b0, 1'b0, 1'b1, 4'd1);
        access("R11 disabled region ignored",    32'h0000_2004, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        write_region(7, 32'h0000_0000, 4'd10, 1'b1, 1'b0, 1'b0, 4'd6);
        access("R5 index 7 over index 2",        32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        write_region(7, 32'h0000_0000, 4'd10, 1'b1, 1'b1, 1'b1, 4'd9);
        access("R8 R10 undefined code attrs",    32'h0000_3000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        clear_all();
    endtask

    task automatic test_same_cycle_write();
        write_region(3, 32'h0000_5000, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd3; cfg_base = 32'h0000_5000; cfg_size = 4'd0;
        cfg_en = 1'b1; cfg_cache = 1'b1; cfg_buf = 1'b0; cfg_perm = 4'd3;
        req_valid = 1'b1; req_addr = 32'h0000_5000; req_write = 1'b0; req_priv = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R2 same-cycle request sees old table", 32'(rsp_fault), 32'd1);
        check("R2 same-cycle old attrs", 32'(rsp_cacheable), 32'd0);
        access("R2 next request sees new table", 32'h0000_5000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        access("R2 other region untouched", 32'h0000_6000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 no request no valid", 32'(rsp_valid), 32'd0);
        check("R9 fault held",          32'(rsp_fault), 32'd1);
        clear_all();
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_size = '0;
        cfg_en = 1'b0; cfg_cache = 1'b0; cfg_buf = 1'b0; cfg_perm = '0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_priv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_perm_table();
        test_size_and_base();
        test_overlap();
        test_same_cycle_write();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule